// File: doc/BRIEF.md
# Quadrature Encoder Fractional Phase Accumulator

This block turns a hand-turned quadrature rotary encoder into a fine-grained, signed phase offset for a waveform generator. Each full quadrature cycle of the encoder is one click. A click moves a signed fixed-point accumulator by a programmable step, in units of 1/256 of a clock cycle, and a held pushbutton makes that step eight times larger for fast scanning. The accumulator stops at its upper and lower limits and never wraps around.

The integer part of the accumulator leaves the block as a signed whole-cycle offset. The 8-bit fraction is not dropped. A first-order sigma-delta modulator adds it up once per waveform period, on a period strobe, and the modulator's overflow becomes a carry bit. The carry adds one extra cycle to the delay on a share of the periods. Averaged over many periods, the delay then equals the fractional value.

All pins are plain control and status signals. There is no data stream, so there is no valid/ready handshake and no back-pressure. The encoder and button inputs may be asynchronous and pass through two synchroniser flops. The step and the period strobe are taken to be in the clock domain already.

Top module: `qpa_top`

## Requirements
- R1: While reset is asserted, and after it is released, `int_offset` is 0 and `sd_carry` is 0. The accumulator and the modulator residue both start from zero.
- R2: With the encoder state written {A,B}, the sequence 00,10,11,01,00 (A leads B) is one forward click and adds the step to the accumulator. The sequence 00,01,11,10,00 is one reverse click and subtracts the step. A click is counted only when the encoder returns to 00.
- R3: Jumps in which both A and B change at once, and partial cycles that turn back before reaching 00, leave the accumulator unchanged.
- R4: When a click is counted with the synchronised button high, the step is `step_in` × 8. The first click counted after the button drops uses `step_in` × 1.
- R5: The accumulator is a 16-bit signed Q8 value that saturates at +32767 (integer +127, fraction 255) and at −32512 (integer −127, fraction 0). It never wraps, even with the largest 8× step of 2040.
- R6: `int_offset` is the accumulator divided by 256 and rounded toward minus infinity (arithmetic shift), so it always lies within ±127.
- R7: On each cycle with `period_tick` high, an 8-bit residue adds the accumulator's low 8 bits. `sd_carry` becomes that sum's ninth bit and holds until the next tick. Without a tick, `sd_carry` does not change.
- R8: A change on A, B or the button is seen in `int_offset` after the third rising clock edge that samples it. When a tick and a counted click fall in the same cycle, the modulator uses the fraction from before the click.
- R9: With `step_in` = 0, clicks in either direction leave the accumulator unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enc_a | input | 1 | Encoder channel A (asynchronous) |
| enc_b | input | 1 | Encoder channel B (asynchronous) |
| fast_btn | input | 1 | Active-high fast-scan button (asynchronous) |
| step_in | input | 8 | Step per click in 1/256-cycle units |
| period_tick | input | 1 | One-cycle strobe, once per waveform period |
| int_offset | output | 8 | Signed integer offset in cycles |
| sd_carry | output | 1 | Sigma-delta carry, one extra cycle of delay |

## Verification
The two functions that can meet in one cycle are a counted click updating the accumulator and a period strobe advancing the modulator from the same accumulator's fraction. The bench keeps period strobes running on a fixed interval while it turns the encoder, so some clicks land on a strobe cycle. It compares the carry on every clock against a reference model in which the modulator reads the fraction from before the click. A second overlap, a button change close to a click, is provoked by releasing the button just before the next click and judging that click by its normal step size.

// File: rtl/qpa_pkg.sv
package qpa_pkg;

  typedef enum logic [1:0] {
    MV_HOLD = 2'd0,
    MV_FWD  = 2'd1,
    MV_BAD  = 2'd2,
    MV_REV  = 2'd3
  } move_e;

  // Position of the encoder around its gray cycle; forward means A leads B.
  function automatic logic [1:0] gray_pos(input logic a, input logic b);
    case ({a, b})
      2'b00:   gray_pos = 2'd0;
      2'b10:   gray_pos = 2'd1;
      2'b11:   gray_pos = 2'd2;
      default: gray_pos = 2'd3;
    endcase
  endfunction

endpackage

// File: rtl/qpa_sync.sv
module qpa_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) stg[0] <= '0;
          else        stg[0] <= d;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) stg[i] <= '0;
          else        stg[i] <= stg[i-1];
      end
    end
  endgenerate

  assign q = stg[STAGES-1];
endmodule

// File: rtl/qpa_quad.sv
module qpa_quad
  import qpa_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic a,
  input  logic b,
  output logic click_up,
  output logic click_dn
);
  logic [1:0]        prev_pos, pos, diff;
  logic signed [3:0] qcnt, nxt;
  move_e             mv;
  logic              at_rest;

  always_comb begin
    pos     = gray_pos(a, b);
    diff    = pos - prev_pos;
    mv      = move_e'(diff);
    case (mv)
      MV_FWD:  nxt = qcnt + 4'sd1;
      MV_REV:  nxt = qcnt - 4'sd1;
      default: nxt = qcnt;
    endcase
    at_rest  = (pos == 2'd0);
    click_up = at_rest && (nxt == 4'sd4);
    click_dn = at_rest && (nxt == -4'sd4);
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      prev_pos <= 2'd0;
      qcnt     <= 4'sd0;
    end else begin
      prev_pos <= pos;
      qcnt     <= at_rest ? 4'sd0 : nxt;
    end

  // R3: a click is never counted both ways at once
  a_r3_one_direction: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({click_up, click_dn}));
  // R2: forward clicks complete from the last quarter, reverse from the first
  a_r2_up_from_last: assert property (@(posedge clk) disable iff (!rst_n)
    click_up |-> (prev_pos == 2'd3));
  a_r2_dn_from_first: assert property (@(posedge clk) disable iff (!rst_n)
    click_dn |-> (prev_pos == 2'd1));
endmodule

// File: rtl/qpa_accum.sv
module qpa_accum #(
  parameter int STEP_W    = 8,
  parameter int FRAC_W    = 8,
  parameter int INT_W     = 8,
  parameter int FAST_SH   = 3,
  parameter int INT_LIMIT = 127
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            click_up,
  input  logic                            click_dn,
  input  logic                            fast,
  input  logic [STEP_W-1:0]               step,
  output logic signed [INT_W+FRAC_W-1:0]  acc
);
  localparam int ACC_W = INT_W + FRAC_W;
  localparam int DLT_W = STEP_W + FAST_SH;
  localparam int SUM_W = ACC_W + 1;
  localparam int HI_I  = INT_LIMIT * (2 ** FRAC_W) + (2 ** FRAC_W) - 1;
  localparam int LO_I  = -(INT_LIMIT * (2 ** FRAC_W));
  localparam logic signed [SUM_W-1:0] SUM_HI = HI_I[SUM_W-1:0];
  localparam logic signed [SUM_W-1:0] SUM_LO = LO_I[SUM_W-1:0];
  localparam logic signed [ACC_W-1:0] ACC_HI = HI_I[ACC_W-1:0];
  localparam logic signed [ACC_W-1:0] ACC_LO = LO_I[ACC_W-1:0];

  logic [DLT_W-1:0]        delta;
  logic signed [SUM_W-1:0] base, ext, sum;

  always_comb begin
    delta = fast ? {step, {FAST_SH{1'b0}}} : {{FAST_SH{1'b0}}, step};
    base  = {acc[ACC_W-1], acc};
    ext   = signed'({{(SUM_W-DLT_W){1'b0}}, delta});
    sum   = click_up ? (base + ext) : (base - ext);
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) acc <= '0;
    else if (click_up || click_dn) begin
      if (sum > SUM_HI)      acc <= ACC_HI;
      else if (sum < SUM_LO) acc <= ACC_LO;
      else                   acc <= sum[ACC_W-1:0];
    end

  // R5: at the limits further clicks outward leave the value pinned
  a_r5_hold_at_max: assert property (@(posedge clk) disable iff (!rst_n)
    (click_up && acc == ACC_HI) |=> (acc == ACC_HI));
  a_r5_hold_at_min: assert property (@(posedge clk) disable iff (!rst_n)
    (click_dn && acc == ACC_LO) |=> (acc == ACC_LO));
  // R3: nothing moves the accumulator between clicks
  a_r3_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !(click_up || click_dn) |=> $stable(acc));
  // R9: a zero step leaves the accumulator alone
  a_r9_zero_step: assert property (@(posedge clk) disable iff (!rst_n)
    (step == '0) |=> $stable(acc));
endmodule

// File: rtl/qpa_sdm.sv
module qpa_sdm #(
  parameter int FRAC_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [FRAC_W-1:0] frac,
  output logic              carry
);
  logic [FRAC_W-1:0] resid;
  logic [FRAC_W:0]   total;

  assign total = {1'b0, resid} + {1'b0, frac};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      resid <= '0;
      carry <= 1'b0;
    end else if (tick) begin
      resid <= total[FRAC_W-1:0];
      carry <= total[FRAC_W];
    end

  // R7: between strobes the modulator is frozen
  a_r7_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> ($stable(carry) && $stable(resid)));
  // R7: a zero fraction can never produce a carry
  a_r7_zero_frac: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && frac == '0) |=> !carry);
endmodule

// File: rtl/qpa_top.sv
module qpa_top #(
  parameter int STEP_W    = 8,
  parameter int FRAC_W    = 8,
  parameter int INT_W     = 8,
  parameter int FAST_SH   = 3,
  parameter int INT_LIMIT = 127,
  parameter int SYNC_N    = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    enc_a,
  input  logic                    enc_b,
  input  logic                    fast_btn,
  input  logic [STEP_W-1:0]       step_in,
  input  logic                    period_tick,
  output logic signed [INT_W-1:0] int_offset,
  output logic                    sd_carry
);
  localparam int ACC_W = INT_W + FRAC_W;

  logic [2:0]              raw_in, syn_in;
  logic                    up, dn;
  logic signed [ACC_W-1:0] acc;

  assign raw_in = {fast_btn, enc_b, enc_a};

  qpa_sync #(.W(3), .STAGES(SYNC_N)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw_in), .q(syn_in)
  );

  qpa_quad u_quad (
    .clk(clk), .rst_n(rst_n), .a(syn_in[0]), .b(syn_in[1]),
    .click_up(up), .click_dn(dn)
  );

  qpa_accum #(
    .STEP_W(STEP_W), .FRAC_W(FRAC_W), .INT_W(INT_W),
    .FAST_SH(FAST_SH), .INT_LIMIT(INT_LIMIT)
  ) u_accum (
    .clk(clk), .rst_n(rst_n), .click_up(up), .click_dn(dn),
    .fast(syn_in[2]), .step(step_in), .acc(acc)
  );

  qpa_sdm #(.FRAC_W(FRAC_W)) u_sdm (
    .clk(clk), .rst_n(rst_n), .tick(period_tick),
    .frac(acc[FRAC_W-1:0]), .carry(sd_carry)
  );

  assign int_offset = acc[ACC_W-1 -: INT_W];

  // R6: the whole-cycle offset never leaves the allowed span
  a_r6_range: assert property (@(posedge clk) disable iff (!rst_n)
    (int_offset <= INT_LIMIT) && (int_offset >= -INT_LIMIT));
endmodule

// File: tb/qpa_top_test.sv
`timescale 1ns/1ps
module qpa_top_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic enc_a = 1'b0, enc_b = 1'b0, fast_btn = 1'b0, period_tick = 1'b0;
  logic [7:0] step_in = 8'd0;
  logic signed [7:0] int_offset;
  logic sd_carry;

  int n_cmp = 0, n_bad = 0;
  string cur_req = "R1";
  bit tick_en = 1'b0, done = 1'b0;
  int cyc = 0;

  always #2.5 clk = ~clk;

  qpa_top uut (.clk(clk), .rst_n(rst_n), .enc_a(enc_a), .enc_b(enc_b),
    .fast_btn(fast_btn), .step_in(step_in), .period_tick(period_tick),
    .int_offset(int_offset), .sd_carry(sd_carry));

  // Reference model state
  int m_s1a = 0, m_s1b = 0, m_s1f = 0, m_s2a = 0, m_s2b = 0, m_s2f = 0;
  int m_prev = 0, m_cnt = 0, m_acc = 0, m_sd = 0, m_carry = 0;
  localparam int HI = 32767, LO = -32512;

  function automatic int qpos(int a, int b);
    if (a == 0 && b == 0) return 0;
    if (a == 1 && b == 0) return 1;
    if (a == 1 && b == 1) return 2;
    return 3;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_s1a = 0; m_s1b = 0; m_s1f = 0; m_s2a = 0; m_s2b = 0; m_s2f = 0;
      m_prev = 0; m_cnt = 0; m_acc = 0; m_sd = 0; m_carry = 0;
    end else begin
      int p, d, nc, stp, t;
      bit up, dn;
      p = qpos(m_s2a, m_s2b);
      d = (p - m_prev) & 3;
      nc = m_cnt + ((d == 1) ? 1 : 0) - ((d == 3) ? 1 : 0);
      up = (p == 0) && (nc == 4);
      dn = (p == 0) && (nc == -4);
      m_cnt = (p == 0) ? 0 : nc;
      stp = (m_s2f != 0) ? int'(step_in) * 8 : int'(step_in);
      if (period_tick) begin
        t = m_sd + (m_acc & 255);
        m_carry = t >> 8;
        m_sd = t & 255;
      end
      if (up) m_acc = (m_acc + stp > HI) ? HI : m_acc + stp;
      if (dn) m_acc = (m_acc - stp < LO) ? LO : m_acc - stp;
      m_prev = p;
      m_s2a = m_s1a; m_s2b = m_s1b; m_s2f = m_s1f;
      m_s1a = int'(enc_a); m_s1b = int'(enc_b); m_s1f = int'(fast_btn);
    end
  end

  // Every-clock comparison against the model
  always @(negedge clk) begin
    if (!done) begin
      n_cmp++;
      if (int_offset !== 8'(m_acc >>> 8) || sd_carry !== 1'(m_carry)) begin
        n_bad++;
        $display("FAIL %s: offset=%0d carry=%0d expected offset=%0d carry=%0d",
                 cur_req, int_offset, sd_carry, m_acc >>> 8, m_carry);
      end
    end
  end

  // Background period strobe
  always @(negedge clk) begin
    cyc++;
    if (tick_en) period_tick <= ((cyc % 5) == 0);
  end

  task automatic put_ab(input logic a, input logic b);
    @(negedge clk); enc_a = a; enc_b = b;
    repeat (2) @(negedge clk);
  endtask

  task automatic click(input bit fwd);
    if (fwd) begin put_ab(1, 0); put_ab(1, 1); put_ab(0, 1); put_ab(0, 0); end
    else     begin put_ab(0, 1); put_ab(1, 1); put_ab(1, 0); put_ab(0, 0); end
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic check_int(input int exp, input string req);
    n_cmp++;
    if (int_offset !== 8'(exp)) begin
      n_bad++;
      $display("FAIL %s: offset=%0d expected=%0d", req, int_offset, exp);
    end
  endtask

  task automatic do_reset();
    tick_en = 1'b0; period_tick = 1'b0;
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk); rst_n = 1'b1;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1; n_bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin : stim
    repeat (3) @(negedge clk);
    cur_req = "R1"; check_int(0, "R1");
    rst_n = 1'b1; settle(); check_int(0, "R1");

    cur_req = "R2"; step_in = 8'd64;
    for (int i = 0; i < 4; i++) click(1);
    settle(); check_int(1, "R2 forward");
    for (int i = 0; i < 8; i++) click(0);
    settle(); check_int(-1, "R6 floor");

    cur_req = "R3";
    put_ab(1, 0); put_ab(1, 1); put_ab(1, 0); put_ab(0, 0);
    put_ab(1, 0); put_ab(0, 1); put_ab(0, 0);
    put_ab(1, 1); put_ab(0, 0);
    settle(); check_int(-1, "R3 partial/invalid");

    cur_req = "R9"; step_in = 8'd0;
    for (int i = 0; i < 3; i++) click(1);
    click(0); settle(); check_int(-1, "R9 zero step");

    cur_req = "R4"; do_reset(); step_in = 8'd32;
    fast_btn = 1'b1; click(1); settle(); check_int(1, "R4 fast x8");
    click(1); fast_btn = 1'b0; click(1); settle();
    check_int(2, "R4 release then normal");   // 256+256+32 = 544

    cur_req = "R5"; step_in = 8'd255; fast_btn = 1'b1; tick_en = 1'b1;
    for (int i = 0; i < 20; i++) click(1);
    settle(); check_int(127, "R5 upper saturation");
    for (int i = 0; i < 40; i++) click(0);
    settle(); check_int(-127, "R5 lower saturation");
    fast_btn = 1'b0;

    cur_req = "R7"; do_reset(); step_in = 8'd64; click(1); settle();
    begin
      int carries = 0;
      for (int i = 0; i < 8; i++) begin
        @(negedge clk); period_tick = 1'b1;
        @(negedge clk); period_tick = 1'b0;
        if (sd_carry) carries++;
        repeat (2) @(negedge clk);
        n_cmp++;
        if (sd_carry !== ((i % 4) == 3)) begin
          n_bad++;
          $display("FAIL R7: carry=%0d expected=%0d at tick %0d",
                   sd_carry, (i % 4) == 3, i);
        end
      end
      n_cmp++;
      if (carries != 2) begin
        n_bad++;
        $display("FAIL R7: carries=%0d expected=2", carries);
      end
    end

    cur_req = "R8"; tick_en = 1'b1;
    for (int s = 1; s < 200; s += 37) begin
      step_in = 8'(s);
      for (int i = 0; i < 5; i++) click((i % 3) != 2);
    end
    settle();
    tick_en = 1'b0; period_tick = 1'b0;
    settle();

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule